// File: doc/BRIEF.md
# Learned DRAM Command Scheduler

This block picks one DRAM command per clock for a memory controller. It does not use a fixed priority ladder. It holds a table of state-action values, learned at run time, and issues the legal command whose stored value is highest, so it favours the choice with the largest expected discounted return.

Each cycle the controller supplies four occupancy counts:

- reads queued;
- writes queued;
- load misses queued;
- waiters on the referenced row (pending writes plus reorder-buffer heads blocked on that row).

The controller also supplies a mask of the commands that the timing checker currently allows. The counts are reduced to small bins that address the value table. A cycle that issues a read or a write earns a reward of one, and every other cycle earns zero.

One cycle after each decision, the block corrects the value of the earlier state-action pair. The correction uses that reward and the value of the pair that was chosen next. On a small, programmable share of cycles it takes a pseudo-random legal command instead of the best one, so that other choices keep being tried.

Top module: `qsched_top`

## Requirements
- R1: `cmd_o` carries one of seven command codes: 0 activate, 1 write, 2 read for a load miss, 3 read for a store miss, 4 precharge for a pending request, 5 preemptive precharge, 6 no-operation. The value 7 never appears.
- R2: Each count is shifted right by `Q_SHIFT` and clipped at 3, giving a 2-bit bin. The table row index is {reads, writes, load misses, row waiters}, with the read bin in bits 7:6. Counts that fall in the same bins address the same row, and counts in different bins address different rows.
- R3: A command is issued only if its bit in `legal_mask_i` is set (bit i enables code i). No-operation is always legal, whatever the state of mask bit 6.
- R4: Without exploration, the block issues the legal command with the largest stored value. On a tie it issues the lowest code.
- R5: The reward for a decision is +1.0 (256 in the signed Q8.8 value format) if the issued code is 1, 2 or 3, and 0 otherwise.
- R6: In every cycle after the first one following reset, the earlier pair (s,a) is written with Q + ((r + Qn - (Qn>>>GAMMA_SHIFT) - Q)>>>ALPHA_SHIFT). Here Qn is the value of the pair chosen in the current cycle, read before the write, and the result is clipped to the 16-bit signed range.
- R7: Reset clears every table entry to zero. The first decision after reset makes no update, so with every command legal it issues activate.
- R8: The exploration generator is a 16-bit shift register, seeded with 0xACE1 at reset. Each cycle it shifts left and takes in bit15^bit13^bit12^bit10. When bits 15:8 are below `explore_thresh_i`, the block computes a random code from bits 2:0 (7 maps to 6). If that code is legal, the block issues it and raises `explore_o`.
- R9: With `explore_thresh_i` at zero, `explore_o` stays low and every pick is the greedy one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_cnt_i | input | CNT_W | Reads waiting in the transaction queue |
| wr_cnt_i | input | CNT_W | Writes waiting in the transaction queue |
| ldmiss_cnt_i | input | CNT_W | Load misses waiting in the transaction queue |
| row_wait_cnt_i | input | CNT_W | Pending writes plus reorder-buffer heads blocked on the referenced row |
| legal_mask_i | input | 7 | Bit i set when command code i meets timing |
| explore_thresh_i | input | 8 | Exploration probability, in units of 1/256 |
| cmd_o | output | 3 | Command issued this cycle |
| explore_o | output | 1 | Command was chosen at random, not greedily |

## Verification
The assertions make the following assumptions about the inputs:

- the legal mask and counts are stable within a cycle and driven to known values whenever reset is low;
- the threshold may change at any cycle;
- nothing is assumed about the mask's contents.

The stimulus therefore drives any mask pattern, including all-clear and only-bit-6 masks, alongside counts that span several bins. It uses a zero-threshold phase in which no-exploration can be asserted, and a nonzero phase that exercises random picks. Inputs change only at the falling edge, so each decision is taken from one settled set of inputs.

// File: rtl/qsched_pkg.sv
package qsched_pkg;

    localparam int NUM_ACT   = 7;
    localparam int ACT_W     = 3;
    localparam int FIELD_W   = 2;
    localparam int NUM_ATTR  = 4;
    localparam int Q_W       = 16;
    localparam int FRAC_W    = 8;
    localparam int LFSR_W    = 16;
    localparam int THR_W     = 8;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef enum logic [ACT_W-1:0] {
        CMD_ACT       = 3'd0,
        CMD_WR        = 3'd1,
        CMD_RD_LOAD   = 3'd2,
        CMD_RD_STORE  = 3'd3,
        CMD_PRE_PEND  = 3'd4,
        CMD_PRE_EARLY = 3'd5,
        CMD_NOP       = 3'd6
    } cmd_e;

    typedef logic signed [Q_W-1:0] qval_t;

    typedef struct packed {
        logic [ACT_W-1:0] act;
        logic             explored;
    } pick_t;

    // Data-moving commands earn the reward.
    function automatic logic is_data_cmd(input logic [ACT_W-1:0] a);
        return (a == CMD_WR) || (a == CMD_RD_LOAD) || (a == CMD_RD_STORE);
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] v);
        logic fb;
        fb = v[15] ^ v[13] ^ v[12] ^ v[10];
        return {v[LFSR_W-2:0], fb};
    endfunction

endpackage

// File: rtl/qsched_quant.sv
module qsched_quant
    import qsched_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int Q_SHIFT = 1,
    localparam int STATE_W = NUM_ATTR * FIELD_W
) (
    input  logic [NUM_ATTR*CNT_W-1:0] cnt_flat_i,
    output logic [STATE_W-1:0]        state_o
);

    localparam logic [CNT_W-1:0] BIN_MAX = CNT_W'((1 << FIELD_W) - 1);

    for (genvar g = 0; g < NUM_ATTR; g++) begin : g_attr
        logic [CNT_W-1:0] scaled;
        assign scaled = cnt_flat_i[g*CNT_W +: CNT_W] >> Q_SHIFT;
        assign state_o[g*FIELD_W +: FIELD_W] =
            (scaled > BIN_MAX) ? BIN_MAX[FIELD_W-1:0] : scaled[FIELD_W-1:0];
    end

endmodule

// File: rtl/qsched_table.sv
module qsched_table
    import qsched_pkg::*;
#(
    parameter int STATE_W = 8,
    localparam int NUM_STATES = 1 << STATE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [STATE_W-1:0]     row_sel_i,
    output logic [NUM_ACT*Q_W-1:0] row_o,
    input  logic [STATE_W-1:0]     pair_state_i,
    input  logic [ACT_W-1:0]       pair_act_i,
    output qval_t                  pair_val_o,
    input  logic                   wr_en_i,
    input  qval_t                  wr_val_i
);

    qval_t mem [NUM_STATES][NUM_ACT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_STATES; s++) begin
                for (int a = 0; a < NUM_ACT; a++) begin
                    mem[s][a] <= '0;
                end
            end
        end else if (wr_en_i) begin
            mem[pair_state_i][pair_act_i] <= wr_val_i;
        end
    end

    for (genvar g = 0; g < NUM_ACT; g++) begin : g_row
        assign row_o[g*Q_W +: Q_W] = mem[row_sel_i][g];
    end

    assign pair_val_o = mem[pair_state_i][pair_act_i];

endmodule

// File: rtl/qsched_select.sv
module qsched_select
    import qsched_pkg::*;
(
    input  logic [NUM_ACT*Q_W-1:0] row_i,
    input  logic [NUM_ACT-1:0]     legal_i,
    input  logic [THR_W-1:0]       roll_i,
    input  logic [ACT_W-1:0]       rand_bits_i,
    input  logic [THR_W-1:0]       thresh_i,
    output pick_t                  pick_o
);

    logic [ACT_W-1:0] best_act;
    qval_t            best_val;
    logic             found;
    logic [ACT_W-1:0] rand_act;

    // Scan upward; strict greater-than keeps the lowest index on ties.
    always_comb begin
        best_act = ACT_W'(CMD_NOP);
        best_val = '0;
        found    = 1'b0;
        for (int i = 0; i < NUM_ACT; i++) begin
            if (legal_i[i] && (!found || ($signed(row_i[i*Q_W +: Q_W]) > best_val))) begin
                best_act = ACT_W'(i);
                best_val = row_i[i*Q_W +: Q_W];
                found    = 1'b1;
            end
        end
    end

    assign rand_act = (rand_bits_i == 3'd7) ? ACT_W'(CMD_NOP) : rand_bits_i;

    always_comb begin
        if ((roll_i < thresh_i) && legal_i[rand_act]) begin
            pick_o.act      = rand_act;
            pick_o.explored = 1'b1;
        end else begin
            pick_o.act      = best_act;
            pick_o.explored = 1'b0;
        end
    end

endmodule

// File: rtl/qsched_update.sv
module qsched_update
    import qsched_pkg::*;
#(
    parameter int ALPHA_SHIFT = 2,
    parameter int GAMMA_SHIFT = 3
) (
    input  qval_t old_i,
    input  qval_t next_i,
    input  logic  rewarded_i,
    output qval_t new_o
);

    localparam int XW = Q_W + 4;
    localparam logic signed [XW-1:0] REWARD_ONE = XW'(1 << FRAC_W);
    localparam logic signed [XW-1:0] Q_MAX = XW'((1 << (Q_W-1)) - 1);
    localparam logic signed [XW-1:0] Q_MIN = -XW'(1 << (Q_W-1));

    logic signed [XW-1:0] old_x, next_x, disc, delta, sum;

    always_comb begin
        old_x  = {{(XW-Q_W){old_i[Q_W-1]}}, old_i};
        next_x = {{(XW-Q_W){next_i[Q_W-1]}}, next_i};
        disc   = next_x - (next_x >>> GAMMA_SHIFT);
        delta  = (rewarded_i ? REWARD_ONE : '0) + disc - old_x;
        sum    = old_x + (delta >>> ALPHA_SHIFT);
        if (sum > Q_MAX) begin
            new_o = Q_MAX[Q_W-1:0];
        end else if (sum < Q_MIN) begin
            new_o = Q_MIN[Q_W-1:0];
        end else begin
            new_o = sum[Q_W-1:0];
        end
    end

endmodule

// File: rtl/qsched_top.sv
module qsched_top
    import qsched_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int Q_SHIFT     = 1,
    parameter int ALPHA_SHIFT = 2,
    parameter int GAMMA_SHIFT = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   rd_cnt_i,
    input  logic [CNT_W-1:0]   wr_cnt_i,
    input  logic [CNT_W-1:0]   ldmiss_cnt_i,
    input  logic [CNT_W-1:0]   row_wait_cnt_i,
    input  logic [NUM_ACT-1:0] legal_mask_i,
    input  logic [THR_W-1:0]   explore_thresh_i,
    output logic [ACT_W-1:0]   cmd_o,
    output logic               explore_o
);

    localparam int STATE_W = NUM_ATTR * FIELD_W;

    logic [STATE_W-1:0]     cur_state;
    logic [NUM_ACT*Q_W-1:0] cur_row;
    logic [NUM_ACT-1:0]     legal;
    pick_t                  pick;
    qval_t                  cur_val, prev_val, upd_val;

    logic [STATE_W-1:0]     prev_state_q;
    logic [ACT_W-1:0]       prev_act_q;
    logic                   prev_valid_q;
    logic [LFSR_W-1:0]      lfsr_q;

    // No-operation is never blocked.
    assign legal = legal_mask_i | (NUM_ACT'(1) << CMD_NOP);

    qsched_quant #(.CNT_W(CNT_W), .Q_SHIFT(Q_SHIFT)) u_quant (
        .cnt_flat_i ({rd_cnt_i, wr_cnt_i, ldmiss_cnt_i, row_wait_cnt_i}),
        .state_o    (cur_state)
    );

    qsched_table #(.STATE_W(STATE_W)) u_table (
        .clk          (clk),
        .rst          (rst),
        .row_sel_i    (cur_state),
        .row_o        (cur_row),
        .pair_state_i (prev_state_q),
        .pair_act_i   (prev_act_q),
        .pair_val_o   (prev_val),
        .wr_en_i      (prev_valid_q),
        .wr_val_i     (upd_val)
    );

    qsched_select u_select (
        .row_i       (cur_row),
        .legal_i     (legal),
        .roll_i      (lfsr_q[LFSR_W-1 -: THR_W]),
        .rand_bits_i (lfsr_q[ACT_W-1:0]),
        .thresh_i    (explore_thresh_i),
        .pick_o      (pick)
    );

    always_comb begin
        cur_val = '0;
        for (int i = 0; i < NUM_ACT; i++) begin
            if (pick.act == ACT_W'(i)) begin
                cur_val = cur_row[i*Q_W +: Q_W];
            end
        end
    end

    qsched_update #(.ALPHA_SHIFT(ALPHA_SHIFT), .GAMMA_SHIFT(GAMMA_SHIFT)) u_update (
        .old_i      (prev_val),
        .next_i     (cur_val),
        .rewarded_i (is_data_cmd(prev_act_q)),
        .new_o      (upd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_state_q <= '0;
            prev_act_q   <= ACT_W'(CMD_NOP);
            prev_valid_q <= 1'b0;
            lfsr_q       <= LFSR_SEED;
        end else begin
            prev_state_q <= cur_state;
            prev_act_q   <= pick.act;
            prev_valid_q <= 1'b1;
            lfsr_q       <= lfsr_step(lfsr_q);
        end
    end

    assign cmd_o     = pick.act;
    assign explore_o = pick.explored;

endmodule

// File: rtl/qsched_checker.sv
module qsched_checker (
    input logic        clk,
    input logic        rst,
    input logic [6:0]  legal_mask_i,
    input logic [7:0]  explore_thresh_i,
    input logic [2:0]  cmd_o,
    input logic        explore_o,
    input logic [15:0] lfsr_q,
    input logic        upd_en
);

    p_code_range_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_o != 3'd7);

    p_cmd_legal_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 3'd6) || legal_mask_i[cmd_o]);

    p_nop_fallback_r3: assert property (@(posedge clk) disable iff (rst)
        (legal_mask_i[5:0] == 6'd0) |-> (cmd_o == 3'd6));

    p_no_update_first_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !upd_en);

    p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != 16'd0);

    p_lfsr_moves_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lfsr_q != $past(lfsr_q)));

    p_no_explore_r9: assert property (@(posedge clk) disable iff (rst)
        (explore_thresh_i == 8'd0) |-> !explore_o);

endmodule

bind qsched_top qsched_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .legal_mask_i     (legal_mask_i),
    .explore_thresh_i (explore_thresh_i),
    .cmd_o            (cmd_o),
    .explore_o        (explore_o),
    .lfsr_q           (lfsr_q),
    .upd_en           (prev_valid_q)
);

// File: tb/qsched_top_tb.sv
`timescale 1ns/1ps
module qsched_top_tb_top;

    localparam int CW = 4;
    localparam int QS = 1;
    localparam int AS = 2;
    localparam int GS = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] rd, wr, lm, rw;
    logic [6:0]    mask;
    logic [7:0]    th;
    logic [2:0]    cmd;
    logic          ex;

    always #2 clk = ~clk;

    qsched_top #(.CNT_W(CW), .Q_SHIFT(QS), .ALPHA_SHIFT(AS), .GAMMA_SHIFT(GS)) dut_i (
        .clk (clk), .rst (rst),
        .rd_cnt_i (rd), .wr_cnt_i (wr), .ldmiss_cnt_i (lm), .row_wait_cnt_i (rw),
        .legal_mask_i (mask), .explore_thresh_i (th),
        .cmd_o (cmd), .explore_o (ex)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int n_explore = 0;

    int qm [256][7];
    int lf;
    int pst, pact;
    bit pvalid;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int binof(input int c);
        int v;
        v = c >> QS;
        return (v > 3) ? 3 : v;
    endfunction

    function automatic int st_idx(input int r, input int w, input int l, input int x);
        return binof(r) * 64 + binof(w) * 16 + binof(l) * 4 + binof(x);
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 256; s++)
            for (int a = 0; a < 7; a++)
                qm[s][a] = 0;
        lf = 16'hACE1;
        pvalid = 0;
        pst = 0;
        pact = 6;
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic cycle(input int r, input int w, input int l, input int x,
                         input int m, input int t, input string req, output int got);
        int s, best, ridx, a, e, m7, qo, qn, rwd, disc, d, nv;
        rd = CW'(r); wr = CW'(w); lm = CW'(l); rw = CW'(x);
        mask = 7'(m); th = 8'(t);
        #1;
        s = st_idx(r, w, l, x);
        m7 = m | 64;
        best = -1;
        for (int i = 0; i < 7; i++)
            if (((m7 >> i) & 1) == 1 && (best < 0 || qm[s][i] > qm[s][best])) best = i;
        ridx = lf & 7;
        if (ridx == 7) ridx = 6;
        if (((lf >> 8) & 255) < t && ((m7 >> ridx) & 1) == 1) begin
            a = ridx; e = 1;
        end else begin
            a = best; e = 0;
        end
        chk(cmd == 3'(a) && ex == 1'(e), {req, " (cmd*2+explore)"},
            int'(cmd) * 2 + int'(ex), a * 2 + e);
        got = int'(cmd);
        if (e == 1) n_explore++;
        if (pvalid) begin
            qo = qm[pst][pact];
            qn = qm[s][a];
            rwd = (pact >= 1 && pact <= 3) ? 256 : 0;
            disc = qn - (qn >>> GS);
            d = rwd + disc - qo;
            nv = qo + (d >>> AS);
            if (nv > 32767) nv = 32767;
            if (nv < -32768) nv = -32768;
            qm[pst][pact] = nv;
        end
        pst = s; pact = a; pvalid = 1;
        lf = ((lf << 1) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1)) & 16'hFFFF;
        @(negedge clk);
    endtask

    initial begin
        int got;
        rd = '0; wr = '0; lm = '0; rw = '0; mask = '0; th = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        cycle(0, 0, 0, 0, 7'h7F, 0, "R7", got);
        chk(got == 0, "R7 reset table picks activate", got, 0);

        cycle(0, 0, 0, 0, 0, 0, "R3", got);
        chk(got == 6, "R3 empty mask gives no-op", got, 6);
        cycle(0, 0, 0, 0, 7'h40, 0, "R3", got);
        chk(got == 6, "R3 only no-op bit", got, 6);

        cycle(0, 0, 0, 0, 7'h02, 0, "R1", got);
        chk(got == 1, "R1 write code", got, 1);
        cycle(0, 0, 0, 0, 7'h02, 0, "R5", got);
        cycle(0, 0, 0, 0, 7'h03, 0, "R5", got);
        chk(got == 1, "R5 R6 rewarded write beats activate", got, 1);

        cycle(1, 0, 0, 0, 7'h03, 0, "R2", got);
        chk(got == 1, "R2 same bin shares row", got, 1);
        cycle(2, 0, 0, 0, 7'h03, 0, "R2", got);
        chk(got == 0, "R2 new bin untrained", got, 0);

        cycle(15, 15, 15, 15, 7'b0110100, 0, "R4", got);
        chk(got == 2, "R4 tie picks lowest code", got, 2);

        n_explore = 0;
        for (int k = 0; k < 1500; k++)
            cycle($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 3),
                  $urandom_range(0, 3), $urandom & 32'h7F, 0, "R4 R6", got);
        chk(n_explore == 0, "R9 no exploration at zero threshold", n_explore, 0);

        n_explore = 0;
        for (int k = 0; k < 1500; k++)
            cycle($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 3),
                  $urandom_range(0, 3), $urandom & 32'h7F, 96, "R8 R6", got);
        chk(n_explore > 0, "R8 exploration occurs", n_explore, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule